// File: doc/BRIEF.md
# Parallel Flash Write-Cycle Sequencer

This block sits between a synchronous controller and the asynchronous bus of a parallel NOR-style flash. A request holds an operation code, an address and a data word, and is taken over a valid/ready handshake. The block then drives the flash reset, chip-enable, write-enable, output-enable and program-enable lines and the address and data buses. Each minimum interval is given in nanoseconds and turned into a count of clock cycles. Every count is rounded up and is never less than one cycle.

A checked write is followed by a busy phase. The block ignores the open-drain ready/busy pin for a blanking window after the strobe rises. It then waits for the pin to go high, reads the status byte, and judges success from bits 1, 3, 4 and 5. Program-enable stays high until that byte has been captured. A plain read returns one data word. Any operation finishes with a one-cycle done strobe that carries its result, and no new request is taken until that strobe has been given.

Top module: `flash_wr_seq`

## Requirements
- R1: While `rst_n` is low, `fl_rst_n` is low, all strobes are high and `req_ready` is low. `fl_rst_n` goes high at the first clock after reset and stays high. `req_ready` first rises RST_CYC-1 cycles after `fl_rst_n` rises, with RST_CYC = ceil(1000 ns / period). No write strobe comes earlier than RST_CYC cycles after `fl_rst_n` rises.
- R2: A write pulse holds `fl_we_n` and `fl_ce_n` low together for exactly WP_CYC cycles, with WP_CYC = ceil(max(70, 55, 50) ns / period). `fl_we_n` is never low unless `fl_ce_n` is low.
- R3: The address and data are captured when the request is accepted. They stay stable while `fl_we_n` is low. `fl_dq_oe` is high only during the pulse and is low in the cycle where `fl_we_n` rises.
- R4: For a plain write (`req_op` = 0), `fl_we_n` stays high for WH_CYC = ceil(max(30, 35) ns / period) cycles before `done`. The done strobe follows the accepting clock edge by WP_CYC+WH_CYC cycles, with `done_ok` = 1. Two writes are always separated by at least WH_CYC cycles of strobe high.
- R5: For a checked write (`req_op` = 1), `fl_oe_n` does not fall earlier than BLANK_CYC = ceil(500 ns / period) cycles after `fl_we_n` rises. It also does not fall before `fl_sts` has returned high.
- R6: The status read holds `fl_ce_n` and `fl_oe_n` low for RD_CYC = ceil(120 ns / period) cycles with `fl_we_n` high, and samples `fl_dq_i` in its last cycle. `rd_data` then carries the status byte. `done_err` = status AND 8'h3A. `done_ok` = 1 exactly when that value is zero.
- R7: `fl_pen` is high whenever `fl_we_n` is low. For a checked write it stays high through the status read. It is low while the block is idle, including in the cycle of `done`, and during a plain read.
- R8: If `fl_sts` is still low after BUSY_TIMEOUT_CYC cycles of the busy phase, `done` is given with `done_timeout` = 1 and `done_ok` = 0. No output-enable pulse occurs and all strobes are high.
- R9: A read (`req_op` = 2 or 3) holds `fl_ce_n` and `fl_oe_n` low for RD_CYC cycles with no write strobe. `rd_data` is the word on `fl_dq_i` in the last of those cycles. `done` follows the accepting edge by RD_CYC cycles.
- R10: `req_ready` is high only when idle. It falls in the cycle after an accepted request, and each request gives exactly one write pulse (none for a read). `done` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_op | input | 2 | 0 write, 1 checked write, 2/3 read |
| req_addr | input | ADDR_W | Flash word address |
| req_data | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion strobe |
| done_ok | output | 1 | Operation succeeded |
| done_timeout | output | 1 | Busy wait expired |
| done_err | output | 8 | Failing status bits |
| rd_data | output | DATA_W | Read word or status byte |
| fl_rst_n | output | 1 | Flash reset/power-down, active low |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_pen | output | 1 | Program enable, active high |
| fl_addr | output | ADDR_W | Address bus |
| fl_dq_o | output | DATA_W | Data bus out |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_dq_i | input | DATA_W | Data bus in |
| fl_sts | input | 1 | Ready/busy, low while busy |

## Verification
Every flash pin comes from a register that loads the next state, so strobe edges line up with state changes. A request set just after a falling clock edge is accepted at the next rising edge. When sampled on falling edges, `done` therefore appears WP_CYC+WH_CYC+1 falling edges after the request was set for a plain write, and RD_CYC+1 for a read. The bench compares these exact spans, the write pulse width and the read pulse width. For checked writes the status wait depends on the pin model, so those checks are lower bounds taken from the strobe's rising edge: the blanking count and the model's own busy time.

// File: rtl/flash_wr_pkg.sv
`timescale 1ns/1ps
package flash_wr_pkg;

  localparam int unsigned STAT_W = 8;
  // status bits that signal a failed operation: 1, 3, 4, 5
  localparam logic [STAT_W-1:0] STAT_FAIL_MASK = 8'b0011_1010;

  typedef enum logic [2:0] {
    ST_REC   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_WLOW  = 3'd2,
    ST_WHIGH = 3'd3,
    ST_BLANK = 3'd4,
    ST_BUSY  = 3'd5,
    ST_RD    = 3'd6
  } fseq_st_e;

  localparam logic [1:0] OP_WRITE = 2'd0;
  localparam logic [1:0] OP_WRCHK = 2'd1;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_ivl_cnt.sv
`timescale 1ns/1ps
module flash_ivl_cnt #(
  parameter int unsigned W    = 8,
  parameter int unsigned INIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign zero = (cnt_q == '0);

  always_comb begin
    cnt_en = load | ~zero;
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= W'(INIT);
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/flash_sts_sync.sv
`timescale 1ns/1ps
module flash_sts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[0] <= 1'b0;
        else        sh_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[g] <= 1'b0;
        else        sh_q[g] <= sh_q[g-1];
      end
    end
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/flash_stat_eval.sv
`timescale 1ns/1ps
module flash_stat_eval #(
  parameter int unsigned          STAT_W = 8,
  parameter logic [STAT_W-1:0]    MASK   = '0
) (
  input  logic [STAT_W-1:0] stat,
  output logic [STAT_W-1:0] bad_bits,
  output logic              bad
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (MASK[i]) begin : g_watch
      assign bad_bits[i] = stat[i];
    end else begin : g_skip
      assign bad_bits[i] = 1'b0;
    end
  end
  assign bad = |bad_bits;
endmodule

// File: rtl/flash_wr_seq.sv
`timescale 1ns/1ps
module flash_wr_seq
  import flash_wr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS    = 5,
  parameter int unsigned ADDR_W           = 24,
  parameter int unsigned DATA_W           = 16,
  parameter int unsigned T_RST_REC_NS     = 1000,
  parameter int unsigned T_WP_NS          = 70,
  parameter int unsigned T_DSU_NS         = 50,
  parameter int unsigned T_ASU_NS         = 55,
  parameter int unsigned T_WPH_NS         = 30,
  parameter int unsigned T_WREC_NS        = 35,
  parameter int unsigned T_BLANK_NS       = 500,
  parameter int unsigned T_RD_NS          = 120,
  parameter int unsigned BUSY_TIMEOUT_CYC = 2048,
  parameter int unsigned STS_SYNC         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              done,
  output logic              done_ok,
  output logic              done_timeout,
  output logic [7:0]        done_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              fl_rst_n,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n,
  output logic              fl_pen,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [DATA_W-1:0] fl_dq_i,
  input  logic              fl_sts
);
  // interval counts
  localparam int unsigned RST_CYC   = ns2cyc(T_RST_REC_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_CYC    = ns2cyc(umax(T_WP_NS, umax(T_ASU_NS, T_DSU_NS)), CLK_PERIOD_NS);
  localparam int unsigned WH_CYC    = ns2cyc(umax(T_WPH_NS, T_WREC_NS), CLK_PERIOD_NS);
  localparam int unsigned BLANK_CYC = ns2cyc(T_BLANK_NS, CLK_PERIOD_NS);
  localparam int unsigned RD_CYC    = ns2cyc(T_RD_NS, CLK_PERIOD_NS);
  localparam int unsigned TO_CYC    = (BUSY_TIMEOUT_CYC == 0) ? 1 : BUSY_TIMEOUT_CYC;
  localparam int unsigned CNT_MAX   = umax(umax(RST_CYC, TO_CYC),
                                      umax(umax(WP_CYC, WH_CYC), umax(BLANK_CYC, RD_CYC)));
  localparam int unsigned CW        = $clog2(CNT_MAX + 1);

  fseq_st_e            st_q, st_d;
  logic                ld, cnt_zero;
  logic [CW-1:0]       ld_val;
  logic                take, fin, fin_to, rd_cap;
  logic                chk_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q;
  logic                sts_ok;
  logic [STAT_W-1:0]   bad_bits;
  logic                bad;
  logic                ce_n_q, we_n_q, oe_n_q, pen_q, dq_oe_q, frst_q;
  logic                ce_n_d, we_n_d, oe_n_d, pen_d, dq_oe_d;
  logic                done_q, ok_q, to_q;
  logic [STAT_W-1:0]   err_q;
  logic [DATA_W-1:0]   rdat_q;

  flash_ivl_cnt #(.W(CW), .INIT(RST_CYC - 1)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .zero(cnt_zero)
  );

  flash_sts_sync #(.STAGES(STS_SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(fl_sts), .dout(sts_ok)
  );

  flash_stat_eval #(.STAT_W(STAT_W), .MASK(STAT_FAIL_MASK)) u_eval (
    .stat(fl_dq_i[STAT_W-1:0]), .bad_bits(bad_bits), .bad(bad)
  );

  // next state
  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    take   = 1'b0;
    fin    = 1'b0;
    fin_to = 1'b0;
    rd_cap = 1'b0;
    unique case (st_q)
      ST_REC:   if (cnt_zero) st_d = ST_IDLE;
      ST_IDLE:  if (req_valid) begin
                  take = 1'b1;
                  ld   = 1'b1;
                  if (req_op[1]) begin
                    st_d   = ST_RD;
                    ld_val = CW'(RD_CYC - 1);
                  end else begin
                    st_d   = ST_WLOW;
                    ld_val = CW'(WP_CYC - 1);
                  end
                end
      ST_WLOW:  if (cnt_zero) begin
                  ld = 1'b1;
                  if (chk_q) begin
                    st_d   = ST_BLANK;
                    ld_val = CW'(BLANK_CYC - 1);
                  end else begin
                    st_d   = ST_WHIGH;
                    ld_val = CW'(WH_CYC - 1);
                  end
                end
      ST_WHIGH: if (cnt_zero) begin
                  st_d = ST_IDLE;
                  fin  = 1'b1;
                end
      ST_BLANK: if (cnt_zero) begin
                  st_d   = ST_BUSY;
                  ld     = 1'b1;
                  ld_val = CW'(TO_CYC - 1);
                end
      ST_BUSY:  if (sts_ok) begin
                  st_d   = ST_RD;
                  ld     = 1'b1;
                  ld_val = CW'(RD_CYC - 1);
                end else if (cnt_zero) begin
                  st_d   = ST_IDLE;
                  fin    = 1'b1;
                  fin_to = 1'b1;
                end
      ST_RD:    if (cnt_zero) begin
                  st_d   = ST_IDLE;
                  fin    = 1'b1;
                  rd_cap = 1'b1;
                end
      default:  st_d = ST_IDLE;
    endcase
  end

  // pin decode of the next state
  always_comb begin
    we_n_d  = (st_d != ST_WLOW);
    dq_oe_d = (st_d == ST_WLOW);
    oe_n_d  = (st_d != ST_RD);
    ce_n_d  = !((st_d == ST_WLOW) || (st_d == ST_RD));
    pen_d   = (st_d == ST_WLOW) || (st_d == ST_WHIGH) || (st_d == ST_BLANK) ||
              (st_d == ST_BUSY) ||
              ((st_d == ST_RD) && ((st_q == ST_BUSY) || ((st_q == ST_RD) && chk_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_REC;
      frst_q   <= 1'b0;
      ce_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      pen_q    <= 1'b0;
      dq_oe_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      frst_q   <= 1'b1;
      ce_n_q   <= ce_n_d;
      we_n_q   <= we_n_d;
      oe_n_q   <= oe_n_d;
      pen_q    <= pen_d;
      dq_oe_q  <= dq_oe_d;
      done_q   <= fin;
    end
  end

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (take) begin
      chk_q  <= (req_op == OP_WRCHK);
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  // results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      to_q   <= 1'b0;
      err_q  <= '0;
      rdat_q <= '0;
    end else begin
      if (rd_cap) rdat_q <= fl_dq_i;
      if (fin) begin
        to_q  <= fin_to;
        ok_q  <= !fin_to && !(chk_q && rd_cap && bad);
        err_q <= (chk_q && rd_cap) ? bad_bits : '0;
      end
    end
  end

  assign req_ready    = (st_q == ST_IDLE);
  assign done         = done_q;
  assign done_ok      = ok_q;
  assign done_timeout = to_q;
  assign done_err     = err_q;
  assign rd_data      = rdat_q;
  assign fl_rst_n     = frst_q;
  assign fl_ce_n      = ce_n_q;
  assign fl_we_n      = we_n_q;
  assign fl_oe_n      = oe_n_q;
  assign fl_pen       = pen_q;
  assign fl_addr      = addr_q;
  assign fl_dq_o      = data_q;
  assign fl_dq_oe     = dq_oe_q;
endmodule

// File: rtl/flash_wr_seq_chk.sv
`timescale 1ns/1ps
module flash_wr_seq_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              done_ok,
  input logic              done_timeout,
  input logic              fl_rst_n,
  input logic              fl_ce_n,
  input logic              fl_we_n,
  input logic              fl_oe_n,
  input logic              fl_pen,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [DATA_W-1:0] fl_dq_o,
  input logic              fl_dq_oe
);
  a_r1_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_rst_n |-> (fl_we_n && fl_ce_n && fl_oe_n));

  a_r2_ce_under_we: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n);

  a_r3_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o)));

  a_r4_high_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |=> fl_we_n);

  a_r6_oe_excl_we: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (fl_we_n && !fl_dq_oe));

  a_r7_pen_over_we: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> fl_pen);

  a_r8_timeout_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_timeout) |-> (!done_ok && fl_oe_n && fl_we_n));

  a_r10_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind flash_wr_seq flash_wr_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .done_ok(done_ok), .done_timeout(done_timeout),
  .fl_rst_n(fl_rst_n), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
  .fl_pen(fl_pen), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe)
);

// File: tb/flash_wr_seq_bench.sv
`timescale 1ns/1ps
module flash_wr_seq_bench;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int PER = 5;

  function automatic int cdiv(input int a);
    return (a + PER - 1) / PER;
  endfunction
  localparam int E_RST   = cdiv(1000);
  localparam int E_WP    = cdiv(70);
  localparam int E_WH    = cdiv(35);
  localparam int E_BLANK = cdiv(500);
  localparam int E_RD    = cdiv(120);

  typedef struct packed {
    logic [1:0]  kind;
    logic [23:0] addr;
    logic [15:0] data;
    logic [15:0] lag;
    logic [15:0] busy;
    logic [7:0]  stat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 24'h000100, 16'h0040, 16'd0,  16'd0,    8'h00},
    '{2'd1, 24'h000100, 16'h1234, 16'd0,  16'd40,   8'h80},
    '{2'd1, 24'h00A5A0, 16'h5A5A, 16'd0,  16'd300,  8'h90},
    '{2'd1, 24'h3FFFFF, 16'hFFFF, 16'd60, 16'd30,   8'h8A},
    '{2'd2, 24'h123456, 16'hBEEF, 16'd0,  16'd0,    8'h00},
    '{2'd1, 24'h000200, 16'h0001, 16'd0,  16'd10,   8'hA8},
    '{2'd1, 24'h000300, 16'h0002, 16'd0,  16'd5000, 8'h80}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic fl_sts = 1'b1;
  logic [DW-1:0] cur_rd = '0;
  logic req_ready, done, done_ok, done_timeout;
  logic [7:0] done_err;
  logic [DW-1:0] rd_data, fl_dq_o;
  logic fl_rst_n, fl_ce_n, fl_we_n, fl_oe_n, fl_pen, fl_dq_oe;
  logic [AW-1:0] fl_addr;

  always #2.5 clk = ~clk;

  flash_wr_seq u_flash_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .done(done), .done_ok(done_ok), .done_timeout(done_timeout),
    .done_err(done_err), .rd_data(rd_data), .fl_rst_n(fl_rst_n),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_pen(fl_pen),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
    .fl_dq_i(cur_rd), .fl_sts(fl_sts)
  );

  int checks = 0, errors = 0;
  int ncyc = 0;
  int cur_lag = 0, cur_busy = 0, m_lag = 0, m_busy = 0;
  int t_rst_rise = -1, t_ready = -1, t_first_fall = -1;
  int t_we_fall = 0, t_we_rise = 0, t_oe_fall = 0, t_oe_rise = 0, t_done = 0;
  int we_falls = 0, oe_falls = 0, pen_viol = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1, prev_rst = 1'b0;
  logic done_seen = 1'b0, pen_at_oe = 1'b0, pen_at_done = 1'b0, dqoe_at_rise = 1'b0;
  logic d_ok = 1'b0, d_to = 1'b0;
  logic [7:0] d_err = '0;
  logic [DW-1:0] d_rd = '0, dq_at_fall = '0;
  logic [AW-1:0] addr_at_fall = '0;

  task automatic chk(input bit good, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // pin monitor and ready/busy model, sampled on falling edges
  always @(negedge clk) begin
    ncyc++;
    if (!prev_rst && fl_rst_n) t_rst_rise = ncyc;
    if (t_ready < 0 && req_ready) t_ready = ncyc;
    if (prev_we && !fl_we_n) begin
      t_we_fall = ncyc; we_falls++;
      if (t_first_fall < 0) t_first_fall = ncyc;
      addr_at_fall = fl_addr; dq_at_fall = fl_dq_o;
    end
    if (!prev_we && fl_we_n) begin
      t_we_rise = ncyc; dqoe_at_rise = fl_dq_oe;
      m_lag = cur_lag; m_busy = cur_busy;
    end
    if (prev_oe && !fl_oe_n) begin t_oe_fall = ncyc; oe_falls++; pen_at_oe = fl_pen; end
    if (!prev_oe && fl_oe_n) t_oe_rise = ncyc;
    if (!fl_we_n && !fl_pen) pen_viol++;
    if (done) begin
      done_seen = 1'b1; t_done = ncyc; d_ok = done_ok; d_to = done_timeout;
      d_err = done_err; d_rd = rd_data; pen_at_done = fl_pen;
    end
    if (m_lag > 0) m_lag--;
    else if (m_busy > 0) begin fl_sts = 1'b0; m_busy--; end
    else fl_sts = 1'b1;
    prev_we = fl_we_n; prev_oe = fl_oe_n; prev_rst = fl_rst_n;
  end

  task automatic run_op(input vec_t v, output int lat, output int nwe, output int noe);
    int wf0, of0, t_set, guard;
    cur_lag  = (v.kind == 2'd1) ? int'(v.lag) : 0;
    cur_busy = (v.kind == 2'd1) ? int'(v.busy) : 0;
    cur_rd   = (v.kind == 2'd1) ? {8'h00, v.stat} : v.data;
    wf0 = we_falls; of0 = oe_falls;
    @(negedge clk); #1;
    done_seen = 1'b0;
    req_valid = 1'b1; req_op = v.kind; req_addr = v.addr; req_data = v.data;
    t_set = ncyc;
    guard = 0;
    while (!done_seen && guard < 6000) begin @(negedge clk); #1; guard++; end
    req_valid = 1'b0;
    chk(done_seen, "R10", "done given", done_seen, 1);
    lat = t_done - t_set; nwe = we_falls - wf0; noe = oe_falls - of0;
  endtask

  initial begin
    #(200000 * PER);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat, nwe, noe, rise1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!fl_rst_n, "R1", "fl_rst_n in reset", fl_rst_n, 0);
    chk(fl_we_n && fl_ce_n && fl_oe_n, "R1", "strobes in reset",
        {fl_we_n, fl_ce_n, fl_oe_n}, 3'b111);
    chk(!req_ready, "R1", "ready in reset", req_ready, 0);
    rst_n = 1'b1;
    while (t_ready < 0) @(negedge clk);
    chk(t_ready - t_rst_rise == E_RST - 1, "R1", "ready after release",
        t_ready - t_rst_rise, E_RST - 1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i], lat, nwe, noe);
      case (VECS[i].kind)
        2'd0: begin
          chk(t_we_rise - t_we_fall == E_WP, "R2", "write pulse", t_we_rise - t_we_fall, E_WP);
          chk(lat == E_WP + E_WH + 1, "R4", "write done span", lat, E_WP + E_WH + 1);
          chk(d_ok, "R4", "write ok", d_ok, 1);
          chk(addr_at_fall == VECS[i].addr, "R3", "address", addr_at_fall, VECS[i].addr);
          chk(dq_at_fall == VECS[i].data, "R3", "data", dq_at_fall, VECS[i].data);
          chk(!dqoe_at_rise, "R3", "bus released", dqoe_at_rise, 0);
          chk(nwe == 1, "R10", "one pulse", nwe, 1);
        end
        2'd1: begin
          chk(t_we_rise - t_we_fall == E_WP, "R2", "checked pulse", t_we_rise - t_we_fall, E_WP);
          chk(nwe == 1, "R10", "one pulse", nwe, 1);
          if (VECS[i].busy > 16'd2048) begin
            chk(d_to && !d_ok, "R8", "timeout flags", {d_to, d_ok}, 2'b10);
            chk(noe == 0, "R8", "no status read", noe, 0);
          end else begin
            chk(t_oe_fall - t_we_rise >= E_BLANK, "R5", "blanking",
                t_oe_fall - t_we_rise, E_BLANK);
            chk(t_oe_fall - t_we_rise >= int'(VECS[i].lag) + int'(VECS[i].busy), "R5",
                "wait for ready", t_oe_fall - t_we_rise, VECS[i].lag + VECS[i].busy);
            chk(t_oe_rise - t_oe_fall == E_RD, "R6", "status read width",
                t_oe_rise - t_oe_fall, E_RD);
            chk(d_rd[7:0] == VECS[i].stat, "R6", "status byte", d_rd[7:0], VECS[i].stat);
            chk(d_err == (VECS[i].stat & 8'h3A), "R6", "fail bits", d_err, VECS[i].stat & 8'h3A);
            chk(d_ok == ((VECS[i].stat & 8'h3A) == 8'h00), "R6", "pass flag",
                d_ok, (VECS[i].stat & 8'h3A) == 8'h00);
            chk(!d_to, "R8", "no timeout", d_to, 0);
            chk(pen_at_oe, "R7", "pen during status read", pen_at_oe, 1);
          end
        end
        default: begin
          chk(lat == E_RD + 1, "R9", "read done span", lat, E_RD + 1);
          chk(d_rd == VECS[i].data, "R9", "read word", d_rd, VECS[i].data);
          chk(nwe == 0, "R9", "no write strobe", nwe, 0);
          chk(t_oe_rise - t_oe_fall == E_RD, "R9", "read width", t_oe_rise - t_oe_fall, E_RD);
          chk(!pen_at_oe, "R7", "pen low on read", pen_at_oe, 1'b0);
        end
      endcase
      chk(!pen_at_done, "R7", "pen low at done", pen_at_done, 0);
      if (i == 0)
        chk(t_first_fall - t_rst_rise >= E_RST, "R1", "first strobe delay",
            t_first_fall - t_rst_rise, E_RST);
    end

    // back-to-back writes: strobe high time between pulses
    run_op(VECS[0], lat, nwe, noe);
    rise1 = t_we_rise;
    run_op(VECS[0], lat, nwe, noe);
    chk(t_we_fall - rise1 >= E_WH, "R4", "high between writes", t_we_fall - rise1, E_WH);
    chk(pen_viol == 0, "R7", "pen during pulses", pen_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule